// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block decides, once per clock, whether a processor core should be asked to take an external interrupt, and with which trap type. It merges fifteen external interrupt level lines with a 17-bit software interrupt register. Two bits of that register are timer-match flags, and both count as level 14. The merged pending vector is compared against the core's current interrupt level threshold. The highest pending level above that threshold is chosen. When the global enable allows it, and any trap already in progress has no higher priority, the block holds a request together with the trap type for that level.

The core and the timers write the software register through separate set and clear masks. The external lines are plain level inputs. The resolver is combinational. A single register stage holds the request flag and the trap type, so an external line change shows on the outputs one clock later. A software register write shows two clocks later, because the register itself adds one stage. All inputs and outputs are plain control signals; none of them uses a valid/ready handshake.

Top module: `irl_resolver`

## Requirements
- R1: Pending level i (1..15) is set when external line i is high or software register bit i is set. Software bits 0 and 16 never set a pending level directly, and pending level 0 is never set.
- R2: Software bit 0 (tick match) or software bit 16 (system tick match) forces pending level 14 on.
- R3: When the pending vector, read as a number, is below 2 shifted left by the current level (`pil_lvl`), the next clock clears `irq_req` and sets `irq_tt` to 0. With `pil_lvl` = 15 this always happens.
- R4: Otherwise the winning level is the highest pending level strictly above `pil_lvl`.
- R5: The trap type for winning level i is 0x40 OR i, in 9 bits.
- R6: While `trap_lvl` is nonzero and `cur_tt` is greater than the new trap type, the outputs keep their previous values. Equal values do not suppress the request.
- R7: With `glb_ie` low and the pending vector at or above the threshold, the next clock clears `irq_req` and `irq_tt`.
- R8: The software register is updated at each clock as `(sw & ~sw_clr) | sw_set`, so a set wins over a clear on the same bit. Its effect on the outputs appears one clock after the update.
- R9: The outputs are registered: an external line change shows after the next rising edge. Reset clears `irq_req`, `irq_tt` and the software register.
- R10: The held outputs change only when the winning trap type differs from the held one, and `irq_req` is high exactly when `irq_tt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl | input | 15 | External level lines, bit i is level i (bits 15..1) |
| sw_set | input | 17 | Software register set mask |
| sw_clr | input | 17 | Software register clear mask |
| pil_lvl | input | 4 | Current processor interrupt level |
| glb_ie | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type of the trap in progress |
| irq_req | output | 1 | Interrupt request to the core |
| irq_tt | output | 9 | Trap type of the requested level |

## Verification
Two functions can act in the same cycle: a software set and a software clear aimed at the same bit, and a threshold change arriving together with a newly winning level. The bench drives a set mask and a clear mask on one bit in the same cycle and expects the level to stay pending. It also raises `pil_lvl` while a new line is asserted and expects either a clear or the new trap type, following the threshold rule. Suppression by a trap in progress is exercised with `cur_tt` above, equal to and below the new trap type.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int unsigned IRL_TT_W    = 9;
  localparam logic [IRL_TT_W-1:0] IRL_TT_BASE = 9'h040;
  localparam int unsigned IRL_LVL_N   = 16;
  localparam int unsigned IRL_SW_W    = 17;
endpackage

// File: rtl/irl_softint_reg.sv
module irl_softint_reg #(
  parameter int unsigned SW_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] set_mask,
  input  logic [SW_W-1:0] clr_mask,
  output logic [SW_W-1:0] sw_q
);
  logic [SW_W-1:0] sw_d;

  always_comb sw_d = (sw_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end
endmodule

// File: rtl/irl_pending_merge.sv
module irl_pending_merge #(
  parameter int unsigned LVL_N     = 16,
  parameter int unsigned SW_W      = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned FOLD_LVL  = 14
) (
  input  logic [LVL_N-1:1] ext_lvl,
  input  logic [SW_W-1:0]  sw_q,
  output logic [LVL_N-1:0] pend
);
  logic timer_hit;

  assign timer_hit = sw_q[TICK_BIT] | sw_q[STICK_BIT];
  assign pend[0]   = 1'b0;

  for (genvar g = 1; g < LVL_N; g++) begin : g_lvl
    if (g == FOLD_LVL) begin : g_fold
      assign pend[g] = ext_lvl[g] | sw_q[g] | timer_hit;
    end else begin : g_plain
      assign pend[g] = ext_lvl[g] | sw_q[g];
    end
  end
endmodule

// File: rtl/irl_priority_pick.sv
module irl_priority_pick #(
  parameter int unsigned LVL_N = 16,
  parameter int unsigned PIL_W = 4,
  localparam int unsigned LVL_W = $clog2(LVL_N)
) (
  input  logic [LVL_N-1:0] pend,
  input  logic [PIL_W-1:0] pil_lvl,
  output logic             below,
  output logic             win_valid,
  output logic [LVL_W-1:0] win_lvl
);
  logic [LVL_N:0]   thresh;
  logic [LVL_N-1:0] qual;

  always_comb thresh = (LVL_N+1)'(2) << pil_lvl;
  always_comb below  = {1'b0, pend} < thresh;

  for (genvar g = 0; g < LVL_N; g++) begin : g_qual
    assign qual[g] = pend[g] && (g > int'(pil_lvl));
  end

  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (qual[i]) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irl_request_hold.sv
module irl_request_hold #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned TL_W  = 3,
  parameter int unsigned TT_W  = 9,
  parameter logic [TT_W-1:0] TT_BASE = 9'h040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             below,
  input  logic             glb_ie,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  cur_tt,
  input  logic [LVL_W-1:0] win_lvl,
  output logic [TT_W-1:0]  new_tt,
  output logic             req_q,
  output logic [TT_W-1:0]  tt_q
);
  logic busy_higher;

  always_comb new_tt      = TT_BASE | TT_W'(win_lvl);
  always_comb busy_higher = (trap_lvl != '0) && (cur_tt > new_tt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else if (below) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else if (glb_ie) begin
      if (!busy_higher && (tt_q != new_tt)) begin
        req_q <= 1'b1;
        tt_q  <= new_tt;
      end
    end else if (req_q) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end
  end
endmodule

// File: rtl/irl_resolver.sv
module irl_resolver
  import irl_pkg::*;
#(
  parameter int unsigned LVL_N     = IRL_LVL_N,
  parameter int unsigned SW_W      = IRL_SW_W,
  parameter int unsigned PIL_W     = 4,
  parameter int unsigned TL_W      = 3,
  parameter int unsigned TT_W      = IRL_TT_W,
  parameter logic [TT_W-1:0] TT_BASE = IRL_TT_BASE,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned FOLD_LVL  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:1] ext_lvl,
  input  logic [SW_W-1:0]  sw_set,
  input  logic [SW_W-1:0]  sw_clr,
  input  logic [PIL_W-1:0] pil_lvl,
  input  logic             glb_ie,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  cur_tt,
  output logic             irq_req,
  output logic [TT_W-1:0]  irq_tt
);
  localparam int unsigned LVL_W = $clog2(LVL_N);

  logic [SW_W-1:0]  sw_q;
  logic [LVL_N-1:0] pend_vec;
  logic             below;
  logic             win_valid;
  logic [LVL_W-1:0] win_lvl;
  logic [TT_W-1:0]  new_tt;

  irl_softint_reg #(.SW_W(SW_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .set_mask(sw_set), .clr_mask(sw_clr), .sw_q(sw_q)
  );

  irl_pending_merge #(
    .LVL_N(LVL_N), .SW_W(SW_W), .TICK_BIT(TICK_BIT),
    .STICK_BIT(STICK_BIT), .FOLD_LVL(FOLD_LVL)
  ) u_merge (
    .ext_lvl(ext_lvl), .sw_q(sw_q), .pend(pend_vec)
  );

  irl_priority_pick #(.LVL_N(LVL_N), .PIL_W(PIL_W)) u_pick (
    .pend(pend_vec), .pil_lvl(pil_lvl), .below(below),
    .win_valid(win_valid), .win_lvl(win_lvl)
  );

  irl_request_hold #(
    .LVL_W(LVL_W), .TL_W(TL_W), .TT_W(TT_W), .TT_BASE(TT_BASE)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .below(below), .glb_ie(glb_ie),
    .trap_lvl(trap_lvl), .cur_tt(cur_tt), .win_lvl(win_lvl),
    .new_tt(new_tt), .req_q(irq_req), .tt_q(irq_tt)
  );
endmodule

// File: rtl/irl_resolver_chk.sv
module irl_resolver_chk #(
  parameter int unsigned LVL_N = 16,
  parameter int unsigned TL_W  = 3,
  parameter int unsigned TT_W  = 9,
  parameter logic [TT_W-1:0] TT_BASE = 9'h040
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glb_ie,
  input logic [TL_W-1:0] trap_lvl,
  input logic [TT_W-1:0] cur_tt,
  input logic            below,
  input logic            win_valid,
  input logic [TT_W-1:0] new_tt,
  input logic            irq_req,
  input logic [TT_W-1:0] irq_tt
);
  localparam logic [TT_W-1:0] LVL_MASK = TT_W'(LVL_N - 1);

  a_r3_below_clears: assert property (@(posedge clk) disable iff (!rst_n)
    below |=> (!irq_req && irq_tt == '0));

  a_r4_scan_matches_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    below == !win_valid);

  a_r5_tt_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_tt & ~LVL_MASK) == TT_BASE));

  a_r6_suppress_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!below && glb_ie && trap_lvl != '0 && cur_tt > new_tt)
      |=> ($stable(irq_tt) && $stable(irq_req)));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_ie |=> !irq_req);

  a_r10_req_tracks_tt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_tt != '0));

  a_r10_same_winner_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!below && glb_ie && new_tt == irq_tt) |=> $stable(irq_tt));
endmodule

bind irl_resolver irl_resolver_chk #(
  .LVL_N(LVL_N), .TL_W(TL_W), .TT_W(TT_W), .TT_BASE(TT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_ie(glb_ie), .trap_lvl(trap_lvl),
  .cur_tt(cur_tt), .below(below), .win_valid(win_valid), .new_tt(new_tt),
  .irq_req(irq_req), .irq_tt(irq_tt)
);

// File: tb/tb_irl_resolver.sv
`timescale 1ns/1ps
module tb_irl_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] ext_lvl = '0;
  logic [16:0] sw_set = '0, sw_clr = '0;
  logic [3:0]  pil_lvl = '0;
  logic        glb_ie = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  cur_tt = '0;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int checks = 0, errors = 0;
  bit done = 0;

  // stimulus staging
  logic [15:1] b_ext = '0;
  logic [16:0] b_set = '0, b_clr = '0;
  logic [3:0]  b_pil = '0;
  logic        b_ie = 1'b0;
  logic [2:0]  b_tl = '0;
  logic [8:0]  b_cur = '0;

  // model state from the requirements
  logic [16:0] m_sw = '0;
  logic        m_req = 1'b0;
  logic [8:0]  m_tt = '0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irl_resolver dut (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .sw_set(sw_set), .sw_clr(sw_clr),
    .pil_lvl(pil_lvl), .glb_ie(glb_ie), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
    .irq_req(irq_req), .irq_tt(irq_tt)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: req/tt actual %0b/%03h expected %0b/%03h",
               tag, act[9], act[8:0], exp[9], exp[8:0]);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input string tag);
    logic [15:0] pend;
    logic [8:0]  ntt;
    int          win;
    @(negedge clk);
    ext_lvl = b_ext; sw_set = b_set; sw_clr = b_clr;
    pil_lvl = b_pil; glb_ie = b_ie; trap_lvl = b_tl; cur_tt = b_cur;
    pend = '0;
    for (int i = 1; i < 16; i++) pend[i] = b_ext[i] | m_sw[i];      // R1
    if (m_sw[0] | m_sw[16]) pend[14] = 1'b1;                        // R2
    if ({1'b0, pend} < (17'd2 << b_pil)) begin                      // R3
      m_req = 1'b0; m_tt = '0;
    end else if (b_ie) begin
      win = 0;
      for (int i = 15; i > 0; i--) if (win == 0 && pend[i] && i > b_pil) win = i; // R4
      ntt = 9'h040 | 9'(win);                                       // R5
      if (!(b_tl != 0 && b_cur > ntt) && m_tt != ntt) begin         // R6, R10
        m_req = 1'b1; m_tt = ntt;
      end
    end else if (m_req) begin                                       // R7
      m_req = 1'b0; m_tt = '0;
    end
    exp_q.push_back({m_req, m_tt});
    tag_q.push_back(tag);
    m_sw = (m_sw & ~b_clr) | b_set;                                 // R8
    b_set = '0; b_clr = '0;
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {irq_req, irq_tt}, e);
    end
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset state", {irq_req, irq_tt}, 10'h000);
    rst_n = 1'b1;
    b_ie = 1'b1;
    step("R9 idle after reset");
    b_ext[5] = 1'b1;  step("R1 R5 R9 line 5");
    step("R10 line 5 held");
    b_ext[9] = 1'b1;  step("R4 line 9 over 5");
    b_pil = 4'd9;     step("R3 pil equals top level");
    b_pil = 4'd8;     step("R4 pil just below 9");
    b_ext = '0; b_pil = 4'd0; step("R1 lines dropped");
    b_set[0] = 1'b1;  step("R8 tick set, one cycle later");
    step("R2 tick folds to 14");
    b_clr[0] = 1'b1; b_set[16] = 1'b1; step("R2 swap tick for stick");
    step("R2 stick folds to 14");
    b_clr[16] = 1'b1; b_set[3] = 1'b1; step("R8 swap to sw level 3");
    step("R1 sw level 3");
    b_set[3] = 1'b1; b_clr[3] = 1'b1; step("R8 set and clear together");
    step("R8 set wins");
    b_pil = 4'd2; b_ext[2] = 1'b1; step("R3 R4 pil and line same cycle");
    b_ie = 1'b0;      step("R7 disabled clears");
    step("R7 stays clear");
    b_ie = 1'b1;      step("R7 re-enabled");
    b_tl = 3'd1; b_cur = 9'h04F; b_ext[12] = 1'b1; step("R6 busy higher suppresses");
    step("R6 still suppressed");
    b_cur = 9'h04C;   step("R6 equal does not suppress");
    b_ext[12] = 1'b0; b_ext[13] = 1'b1; b_cur = 9'h04A; step("R6 lower in progress");
    b_tl = 3'd0; b_cur = 9'h07F; b_ext[15] = 1'b1; step("R6 trap level zero ignores cur_tt");
    b_pil = 4'd15;    step("R3 pil 15 blocks all");
    b_pil = 4'd14;    step("R4 level 15 over pil 14");
    b_ext = '0; b_clr = '1; step("R1 all cleared");
    step("R1 idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule